// File: doc/BRIEF.md
# Prioritized Serial Status Readout

This block sends one of two status words out over a single serial data line. One word carries a converter result with its done flag. The other carries a frequency count with its done flag. A control-register write sets one or both of the request bits `rd_adc_o` and `rd_cnt_o`. When the active-low frame enable `en_n` falls, the block picks a word by fixed priority, with the converter first. It loads that word into a shift register, together with snapshots of two input pins. On each cycle that `sck` is high while `en_n` is low, the word moves out one bit, MSB first.

While a request is pending, every register write from the surrounding serial write decoder is blocked. The decoder sees this on `wr_grant`. When `en_n` rises after at least a full frame has been clocked, the request that was served clears itself. A frame that stops early leaves the request in place, so the host can read the word again. The block runs on the system clock, and `sck` is a one-cycle shift strobe in that domain.

Top module: `status_readout`

## Requirements
- R1: After reset, both request bits are 0 and `sdo` is 0.
- R2: With no request pending, `wr_grant` equals `wr_req`. A granted write with `wr_ctl`=1 loads `wr_rd_adc`/`wr_rd_cnt` into the request bits, visible one cycle later.
- R3: While either request bit is 1, `wr_grant` is 0 and writes do not change the request bits.
- R4: If both requests are set when `en_n` falls, the converter word is sent. The counter request stays set after that frame.
- R5: A converter frame sends bits in this order: done flag, pin C, then the 6-bit result from MSB to LSB. That is 8 bits in all.
- R6: A counter frame sends bits in this order: done flag, pin D, then the 22-bit count from MSB to LSB. That is 24 bits in all.
- R7: Pin C and pin D levels are captured in the cycle in which the fall of `en_n` is seen. Later changes on the pins do not alter the frame.
- R8: On the rise of `en_n`, the served request bit clears once at least its frame length (8 or 24) of shifts has occurred.
- R9: A frame ended with fewer shifts than its length leaves the request bit set.
- R10: With no request pending, a frame sends only zeros and leaves both request bits at 0.
- R11: A converter frame extended past 8 bits sends pin D as its 9th bit, followed by zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Register write strobe from the write decoder |
| wr_ctl | input | 1 | The write targets the control register |
| wr_rd_adc | input | 1 | Converter read request value for a control write |
| wr_rd_cnt | input | 1 | Counter read request value for a control write |
| wr_grant | output | 1 | Write allowed this cycle |
| adc_val | input | 6 | Converter result |
| adc_done | input | 1 | Converter done flag |
| cnt_val | input | 22 | Frequency count |
| cnt_done | input | 1 | Count done flag |
| pin_c | input | 1 | Input pin C level |
| pin_d | input | 1 | Input pin D level |
| en_n | input | 1 | Active-low frame enable |
| sck | input | 1 | Shift strobe |
| sdo | output | 1 | Serial data out |
| rd_adc_o | output | 1 | Converter read request |
| rd_cnt_o | output | 1 | Counter read request |

## Verification
The frame's first bit appears on `sdo` one cycle after `en_n` is driven low, since the load happens on that edge. Each later bit appears one cycle after a cycle with `sck` high. Request changes, from a granted write or from an auto-clear at the rise of `en_n`, show up one cycle after the stimulus. `wr_grant` is valid in the same cycle as `wr_req`. The bench drives inputs just after a falling edge and samples at the next falling edge, so every registered result is compared exactly one edge after its cause. A behavioural queue model checks every output on every cycle. Separate checks compare each collected frame with a packing function.

// File: rtl/status_readout.sv
module status_readout #(
  parameter int ADC_W = 6,
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             wr_ctl,
  input  logic             wr_rd_adc,
  input  logic             wr_rd_cnt,
  output logic             wr_grant,
  input  logic [ADC_W-1:0] adc_val,
  input  logic             adc_done,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_done,
  input  logic             pin_c,
  input  logic             pin_d,
  input  logic             en_n,
  input  logic             sck,
  output logic             sdo,
  output logic             rd_adc_o,
  output logic             rd_cnt_o
);
  localparam int ADC_LEN = ADC_W + 2;
  localparam int CNT_LEN = CNT_W + 2;
  localparam int SR_W    = CNT_LEN;
  localparam int PAD_W   = SR_W - ADC_LEN - 1;
  localparam int CW      = $clog2(SR_W + 2);

  logic            rd_adc, rd_cnt, en_q;
  logic            sel_adc, sel_cnt;
  logic [SR_W-1:0] sr;
  logic [CW-1:0]   nshift;

  wire pending   = rd_adc | rd_cnt;
  wire start     = en_q & ~en_n;
  wire stop      = ~en_q & en_n;
  wire shift     = ~en_q & ~en_n & sck;
  wire adc_full  = nshift >= CW'(ADC_LEN);
  wire cnt_full  = nshift >= CW'(CNT_LEN);

  assign wr_grant = wr_req & ~pending;
  assign sdo      = sr[SR_W-1];
  assign rd_adc_o = rd_adc;
  assign rd_cnt_o = rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      sr      <= '0;
      nshift  <= '0;
      sel_adc <= 1'b0;
      sel_cnt <= 1'b0;
    end else begin
      en_q <= en_n;
      if (start) begin
        sel_adc <= rd_adc;
        sel_cnt <= ~rd_adc & rd_cnt;
        nshift  <= '0;
        if (rd_adc)
          sr <= {adc_done, pin_c, adc_val, pin_d, {PAD_W{1'b0}}};
        else if (rd_cnt)
          sr <= {cnt_done, pin_d, cnt_val};
        else
          sr <= '0;
      end else if (shift) begin
        sr <= {sr[SR_W-2:0], 1'b0};
        if (nshift != {CW{1'b1}}) nshift <= nshift + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_adc <= 1'b0;
      rd_cnt <= 1'b0;
    end else if (wr_grant && wr_ctl) begin
      rd_adc <= wr_rd_adc;
      rd_cnt <= wr_rd_cnt;
    end else if (stop) begin
      if (sel_adc && adc_full) rd_adc <= 1'b0;
      if (sel_cnt && cnt_full) rd_cnt <= 1'b0;
    end
  end

  // R3
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adc && wr_req && wr_ctl && !wr_rd_adc && !stop) |=> rd_adc);

  // R4
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_adc && rd_cnt) |=> (sel_adc && !sel_cnt));

  // R8
  clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_adc) || $fell(rd_cnt)) |-> ($past(stop) || $past(wr_grant)));

  // R9
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && sel_adc && !adc_full) |=> rd_adc);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_adc && !rd_cnt) |=> !sdo);
endmodule

// File: tb/status_readout_tb.sv
module status_readout_tb;
  localparam int CLK_P = 10;
  localparam int AW = 6, CWD = 22, SRW = CWD + 2;

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, wr_ctl = 0, wr_rd_adc = 0, wr_rd_cnt = 0, wr_grant;
  logic [AW-1:0] adc_val = 0;
  logic [CWD-1:0] cnt_val = 0;
  logic adc_done = 0, cnt_done = 0, pin_c = 0, pin_d = 0;
  logic en_n = 1, sck = 0, sdo, rd_adc_o, rd_cnt_o;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";

  status_readout u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // behavioural model
  bit m_adc, m_cnt, m_prev = 1;
  int m_sel, m_sh;
  bit m_q[$];

  function automatic void pack(int sel, output bit q[$]);
    q = {};
    if (sel == 1) begin
      q.push_back(adc_done); q.push_back(pin_c);
      for (int i = AW-1; i >= 0; i--) q.push_back(adc_val[i]);
      q.push_back(pin_d);
    end else if (sel == 2) begin
      q.push_back(cnt_done); q.push_back(pin_d);
      for (int i = CWD-1; i >= 0; i--) q.push_back(cnt_val[i]);
    end
    while (q.size() < SRW) q.push_back(0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_adc = 0; m_cnt = 0; m_prev = 1; m_q = {}; m_sh = 0; m_sel = 0;
    end else begin
      bit g;
      g = wr_req && !m_adc && !m_cnt;
      if (m_prev && !en_n) begin
        m_sel = m_adc ? 1 : (m_cnt ? 2 : 0);
        pack(m_sel, m_q);
        m_sh = 0;
      end else if (!m_prev && !en_n && sck) begin
        void'(m_q.pop_front()); m_q.push_back(0); m_sh++;
      end
      if (g && wr_ctl) begin
        m_adc = wr_rd_adc; m_cnt = wr_rd_cnt;
      end else if (!m_prev && en_n) begin
        if (m_sel == 1 && m_sh >= AW + 2) m_adc = 0;
        if (m_sel == 2 && m_sh >= SRW) m_cnt = 0;
      end
      m_prev = en_n;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(phase, "sdo", sdo, (m_q.size() > 0) ? m_q[0] : 0);
    chk(phase, "rd_adc", rd_adc_o, m_adc);
    chk(phase, "rd_cnt", rd_cnt_o, m_cnt);
    chk(phase, "wr_grant", wr_grant, wr_req && !m_adc && !m_cnt);
  end

  task automatic wr(bit ctl, bit a, bit c);
    wr_req = 1; wr_ctl = ctl; wr_rd_adc = a; wr_rd_cnt = c;
    @(negedge clk); #1;
    wr_req = 0; wr_ctl = 0;
  endtask

  task automatic frame(int n, bit flip_pins, output bit [SRW-1:0] got);
    got = '0;
    en_n = 0; sck = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i < SRW) got[SRW-1-i] = sdo;
      #1;
      if (i == 0 && flip_pins) begin pin_c = ~pin_c; pin_d = ~pin_d; end
      sck = 1;
    end
    @(negedge clk); #1;
    sck = 0; en_n = 1;
    @(negedge clk); #1;
  endtask

  function automatic bit [SRW-1:0] exp_word(int sel, bit pc, bit pd);
    if (sel == 1) return {adc_done, pc, adc_val, pd, 15'b0};
    if (sel == 2) return {cnt_done, pd, cnt_val};
    return '0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [SRW-1:0] got;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "reset rd_adc", rd_adc_o, 0);
    chk("R1", "reset rd_cnt", rd_cnt_o, 0);
    chk("R1", "reset sdo", sdo, 0);
    #1;

    phase = "R10";
    frame(24, 0, got);
    chk("R10", "idle frame", got, 0);
    chk("R10", "idle requests", {rd_adc_o, rd_cnt_o}, 0);

    phase = "R2";
    wr(1, 1, 0);
    chk("R2", "rd_adc set", rd_adc_o, 1);

    phase = "R3";
    wr_req = 1; wr_ctl = 1; wr_rd_adc = 0; wr_rd_cnt = 1;
    @(negedge clk);
    chk("R3", "grant blocked", wr_grant, 0);
    #1 wr_req = 0; wr_ctl = 0;
    @(negedge clk);
    chk("R3", "requests held", {rd_adc_o, rd_cnt_o}, 2'b10);
    #1;

    phase = "R5";
    adc_val = 6'b101101; adc_done = 1; pin_c = 1; pin_d = 0;
    frame(8, 1, got);
    chk("R5", "adc frame", got[SRW-1 -: 8], exp_word(1, 1, 0) >> 16);
    chk("R7", "pin_c snapshot", got[SRW-2], 1);
    chk("R8", "adc auto clear", rd_adc_o, 0);

    phase = "R6";
    wr(1, 0, 1);
    cnt_val = 22'h2A5C3F; cnt_done = 1; pin_d = 1;
    frame(24, 1, got);
    chk("R6", "cnt frame", got, exp_word(2, 0, 1));
    chk("R7", "pin_d snapshot", got[SRW-2], 1);
    chk("R8", "cnt auto clear", rd_cnt_o, 0);

    phase = "R4";
    wr(1, 1, 1);
    adc_val = 6'b010011; adc_done = 0; pin_c = 0; pin_d = 0;
    frame(8, 0, got);
    chk("R4", "adc wins", got[SRW-1 -: 8], exp_word(1, 0, 0) >> 16);
    chk("R4", "cnt kept", {rd_adc_o, rd_cnt_o}, 2'b01);

    phase = "R9";
    cnt_val = 22'h155555; cnt_done = 0;
    frame(5, 0, got);
    chk("R9", "short frame keeps rd_cnt", rd_cnt_o, 1);
    frame(24, 0, got);
    chk("R9", "full reread", got, exp_word(2, 0, 0));
    chk("R8", "clear after reread", rd_cnt_o, 0);

    phase = "R11";
    wr(1, 1, 0);
    adc_val = 6'b111000; adc_done = 1; pin_c = 0; pin_d = 1;
    frame(16, 0, got);
    chk("R11", "extended adc frame", got[SRW-1 -: 16], exp_word(1, 0, 1) >> 8);
    chk("R11", "ninth bit pin_d", got[SRW-9], 1);
    chk("R8", "clear after long frame", rd_adc_o, 0);

    phase = "R2";
    wr_req = 1;
    @(negedge clk);
    chk("R2", "grant when idle", wr_grant, 1);
    #1 wr_req = 0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule